// File: doc/BRIEF.md
# Pipelined Neuron MAC with Sigmoid Lookup

This block computes one artificial neuron at a time from a stream of synapses. Every clock it can take one signed weight and one signed activation, both 32-bit fixed point with a parameterised number of fraction bits (15 by default). It multiplies them in a radix-4 Booth multiplier that keeps its partial sum in carry-save form across four stages, four Booth digits per stage. A fifth stage resolves the product, rescales it and saturates it to a 32-bit two's-complement word. A sixth stage adds it into a saturating 32-bit accumulator.

A flag marks the last synapse of a neuron and travels down the pipe with the data. When the flagged synapse has been accumulated, the seventh stage presents the raw sum and its sigmoid. The sigmoid is read from a small table that is computed at elaboration. The accumulator restarts from zero for the next neuron with no gap cycle. Cycles with no valid input are bubbles: they pass through the pipe and have no effect on any sum.

Top module: `neuron_mac_sigmoid`

## Requirements
- R1: While reset is held and after it is released, with no input applied, `out_valid` is 0 and `out_sum` and `out_act` are 0.
- R2: Each valid synapse contributes floor(weight × activation / 2^15), with both operands treated as signed. A neuron's `out_sum` is the running sum of these contributions. A new synapse may be applied in every clock cycle.
- R3: `out_valid` rises for exactly one cycle, 7 rising clock edges after the edge that samples a synapse with `in_last` = 1.
- R4: A product that does not fit in a signed 32-bit word is clamped to 0x7FFFFFFF or 0x80000000 before accumulation. This includes the operand pair −2^31 × −2^31.
- R5: When an accumulation overflows, the sum is clamped to 0x7FFFFFFF or 0x80000000 instead of wrapping.
- R6: The synapse that follows one flagged `in_last` starts a new neuron from a sum of zero, even when the two are applied in consecutive cycles.
- R7: Cycles with `in_valid` = 0 change neither the accumulated sum nor the reported result.
- R8: `out_act` is unsigned, with 2 integer bits and 15 fraction bits. Its value is round(32768 · 1/(1+e^−x)), where x = (idx − 31.5)/16. idx is the 6-bit value formed by bits 16..11 of the sum (clamped as in R9) with bit 16 inverted. `out_act` is at least 16384 for a non-negative sum and at most 16384 for a negative one.
- R9: Before indexing, a sum above 65535 is clamped to 65535 and a sum below −65536 is clamped to −65536. Large sums therefore select table entry 63 or entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A synapse is presented this cycle |
| in_last | input | 1 | This synapse is the neuron's final one |
| in_weight | input | 32 | Signed fixed-point weight |
| in_act | input | 32 | Signed fixed-point input activation |
| out_valid | output | 1 | One-cycle pulse: a neuron result is present |
| out_sum | output | 32 | Saturated neuron sum before the sigmoid |
| out_act | output | 17 | Sigmoid of the sum, 2 integer and 15 fraction bits |

## Verification
Ending a neuron and starting the next can fall in the same cycle. The lookup stage reads the finished sum of one neuron on the same edge at which the accumulator takes in the first product of the next neuron from a zero base. The bench provokes this by applying back-to-back neurons, including one-synapse neurons, with no idle cycle between them. It judges the result by requiring each reported sum and sigmoid to match that neuron's own products alone, and by requiring each pulse to arrive exactly 7 edges after its last synapse.

// File: rtl/nsig_pkg.sv
package nsig_pkg;
  localparam int OP_W   = 32;
  localparam int PROD_W = 2 * OP_W;
  localparam int DIGITS = OP_W / 2;

  typedef struct packed {
    logic [PROD_W-1:0] sum;
    logic [PROD_W-1:0] carry;
  } csa_t;

  // One radix-4 Booth partial product, sign-extended and placed at its weight.
  function automatic logic [PROD_W-1:0] booth_pp(input logic [OP_W-1:0] x,
                                                 input logic [2:0] grp,
                                                 input int shift);
    logic [PROD_W-1:0] xe;
    logic [PROD_W-1:0] v;
    xe = {{(PROD_W-OP_W){x[OP_W-1]}}, x};
    case (grp)
      3'b001, 3'b010: v = xe;
      3'b011:         v = xe << 1;
      3'b100:         v = -(xe << 1);
      3'b101, 3'b110: v = -xe;
      default:        v = '0;
    endcase
    return v << shift;
  endfunction

  // Three-to-two compressor over the full product width.
  function automatic csa_t csa3(input logic [PROD_W-1:0] a,
                                input logic [PROD_W-1:0] b,
                                input logic [PROD_W-1:0] c);
    csa_t r;
    r.sum   = a ^ b ^ c;
    r.carry = ((a & b) | (a & c) | (b & c)) << 1;
    return r;
  endfunction

  // Rescale a full product by frac bits and clamp into a signed 32-bit word.
  function automatic logic [OP_W-1:0] sat_product(input logic [PROD_W-1:0] full,
                                                  input int frac);
    logic signed [PROD_W-1:0] sh;
    sh = $signed(full) >>> frac;
    if (sh > $signed({{(PROD_W-OP_W+1){1'b0}}, {(OP_W-1){1'b1}}}))
      return {1'b0, {(OP_W-1){1'b1}}};
    else if (sh < $signed({{(PROD_W-OP_W+1){1'b1}}, {(OP_W-1){1'b0}}}))
      return {1'b1, {(OP_W-1){1'b0}}};
    else
      return sh[OP_W-1:0];
  endfunction

  // Signed saturating add.
  function automatic logic [OP_W-1:0] sat_add(input logic [OP_W-1:0] a,
                                              input logic [OP_W-1:0] b);
    logic [OP_W:0] s;
    s = {a[OP_W-1], a} + {b[OP_W-1], b};
    if (s[OP_W] != s[OP_W-1])
      return s[OP_W] ? {1'b1, {(OP_W-1){1'b0}}} : {1'b0, {(OP_W-1){1'b1}}};
    return s[OP_W-1:0];
  endfunction

  // e^(-a) for a >= 0 by a truncated series.
  function automatic real exp_neg(input real a);
    real term;
    real total;
    term  = 1.0;
    total = 1.0;
    for (int k = 1; k < 40; k++) begin
      term  = term * (-a) / k;
      total = total + term;
    end
    return total;
  endfunction

  // Table entry: sigmoid sampled at the midpoint of the bucket selected by idx.
  function automatic int sig_code(input int idx, input int addr_w,
                                  input int in_w, input int in_frac,
                                  input int out_frac);
    real x;
    real e;
    real s;
    real step;
    step = real'(1 << (in_w - addr_w)) / real'(1 << in_frac);
    x    = (real'(idx - (1 << (addr_w - 1))) + 0.5) * step;
    e    = exp_neg(x < 0.0 ? -x : x);
    s    = (x >= 0.0) ? 1.0 / (1.0 + e) : e / (1.0 + e);
    return $rtoi(s * real'(1 << out_frac) + 0.5);
  endfunction
endpackage

// File: rtl/nsig_booth_stage.sv
module nsig_booth_stage
  import nsig_pkg::*;
#(
  parameter int FIRST_DIGIT = 0,
  parameter int STEP_DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              last_i,
  input  logic [OP_W-1:0]   x_i,
  input  logic [OP_W-1:0]   y_i,
  input  logic [PROD_W-1:0] s_i,
  input  logic [PROD_W-1:0] c_i,
  output logic              vld_o,
  output logic              last_o,
  output logic [OP_W-1:0]   x_o,
  output logic [OP_W-1:0]   y_o,
  output logic [PROD_W-1:0] s_o,
  output logic [PROD_W-1:0] c_o
);
  logic [OP_W:0]     ye;
  logic [PROD_W-1:0] s_chain [STEP_DIGITS+1];
  logic [PROD_W-1:0] c_chain [STEP_DIGITS+1];

  assign ye         = {y_i, 1'b0};
  assign s_chain[0] = s_i;
  assign c_chain[0] = c_i;

  for (genvar d = 0; d < STEP_DIGITS; d++) begin : g_digit
    localparam int DIG = FIRST_DIGIT + d;
    csa_t r;
    assign r            = csa3(s_chain[d], c_chain[d], booth_pp(x_i, ye[2*DIG +: 3], 2*DIG));
    assign s_chain[d+1] = r.sum;
    assign c_chain[d+1] = r.carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      last_o <= 1'b0;
    end else begin
      vld_o  <= vld_i;
      last_o <= vld_i & last_i;
    end
  end

  always_ff @(posedge clk) begin
    x_o <= x_i;
    y_o <= y_i;
    s_o <= s_chain[STEP_DIGITS];
    c_o <= c_chain[STEP_DIGITS];
  end
endmodule

// File: rtl/nsig_sigmoid_rom.sv
module nsig_sigmoid_rom
  import nsig_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int IN_FRAC = 15,
  parameter int OUT_W   = 17
) (
  input  logic [OP_W-1:0]  sum_i,
  output logic [OUT_W-1:0] act_o
);
  localparam int IN_W  = IN_FRAC + 2;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic signed [OP_W-1:0] HI = (1 <<< (IN_W - 1)) - 1;
  localparam logic signed [OP_W-1:0] LO = -(1 <<< (IN_W - 1));

  logic [OUT_W-1:0]  table_q [DEPTH];
  logic [OP_W-1:0]   clamped;
  logic [ADDR_W-1:0] idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_q[g] = OUT_W'(sig_code(g, ADDR_W, IN_W, IN_FRAC, OUT_W - 2));
  end

  always_comb begin
    if ($signed(sum_i) > HI)      clamped = HI;
    else if ($signed(sum_i) < LO) clamped = LO;
    else                          clamped = sum_i;
  end

  assign idx   = clamped[IN_W-1 -: ADDR_W] ^ ADDR_W'(1 << (ADDR_W - 1));
  assign act_o = table_q[idx];
endmodule

// File: rtl/neuron_mac_sigmoid.sv
module neuron_mac_sigmoid
  import nsig_pkg::*;
#(
  parameter int FRAC_W       = 15,
  parameter int LUT_ADDR_W   = 6,
  parameter int LUT_OUT_FRAC = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_last,
  input  logic [31:0]             in_weight,
  input  logic [31:0]             in_act,
  output logic                    out_valid,
  output logic [31:0]             out_sum,
  output logic [LUT_OUT_FRAC+1:0] out_act
);
  localparam int MUL_STAGES  = 4;
  localparam int STEP_DIGITS = DIGITS / MUL_STAGES;
  localparam int ACT_W       = LUT_OUT_FRAC + 2;

  logic              v_pipe [MUL_STAGES+1];
  logic              l_pipe [MUL_STAGES+1];
  logic [OP_W-1:0]   x_pipe [MUL_STAGES+1];
  logic [OP_W-1:0]   y_pipe [MUL_STAGES+1];
  logic [PROD_W-1:0] s_pipe [MUL_STAGES+1];
  logic [PROD_W-1:0] c_pipe [MUL_STAGES+1];

  assign v_pipe[0] = in_valid;
  assign l_pipe[0] = in_last;
  assign x_pipe[0] = in_weight;
  assign y_pipe[0] = in_act;
  assign s_pipe[0] = '0;
  assign c_pipe[0] = '0;

  for (genvar st = 0; st < MUL_STAGES; st++) begin : g_mul
    nsig_booth_stage #(
      .FIRST_DIGIT(st * STEP_DIGITS),
      .STEP_DIGITS(STEP_DIGITS)
    ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (v_pipe[st]),
      .last_i(l_pipe[st]),
      .x_i   (x_pipe[st]),
      .y_i   (y_pipe[st]),
      .s_i   (s_pipe[st]),
      .c_i   (c_pipe[st]),
      .vld_o (v_pipe[st+1]),
      .last_o(l_pipe[st+1]),
      .x_o   (x_pipe[st+1]),
      .y_o   (y_pipe[st+1]),
      .s_o   (s_pipe[st+1]),
      .c_o   (c_pipe[st+1])
    );
  end

  // Stage 5: resolve carry-save, rescale, saturate.
  logic            p5_valid;
  logic            p5_last;
  logic [OP_W-1:0] p5_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p5_valid <= 1'b0;
      p5_last  <= 1'b0;
      p5_prod  <= '0;
    end else begin
      p5_valid <= v_pipe[MUL_STAGES];
      p5_last  <= v_pipe[MUL_STAGES] & l_pipe[MUL_STAGES];
      p5_prod  <= sat_product(s_pipe[MUL_STAGES] + c_pipe[MUL_STAGES], FRAC_W);
    end
  end

  // Stage 6: saturating accumulation; a new neuron starts from zero.
  logic            acc_valid;
  logic            acc_last;
  logic            fresh_q;
  logic [OP_W-1:0] acc_q;
  logic [OP_W-1:0] acc_base;
  logic [OP_W-1:0] acc_next;

  assign acc_base = fresh_q ? '0 : acc_q;
  assign acc_next = sat_add(acc_base, p5_prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_last  <= 1'b0;
      fresh_q   <= 1'b1;
      acc_q     <= '0;
    end else begin
      acc_valid <= p5_valid;
      acc_last  <= p5_valid & p5_last;
      if (p5_valid) begin
        acc_q   <= acc_next;
        fresh_q <= p5_last;
      end
    end
  end

  // Stage 7: sigmoid lookup of a finished neuron.
  logic             neuron_end;
  logic [ACT_W-1:0] lut_act;

  assign neuron_end = acc_valid & acc_last;

  nsig_sigmoid_rom #(
    .ADDR_W (LUT_ADDR_W),
    .IN_FRAC(FRAC_W),
    .OUT_W  (ACT_W)
  ) u_rom (
    .sum_i(acc_q),
    .act_o(lut_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_act   <= '0;
    end else begin
      out_valid <= neuron_end;
      if (neuron_end) begin
        out_sum <= acc_q;
        out_act <= lut_act;
      end
    end
  end
endmodule

// File: rtl/nsig_core_chk.sv
module nsig_core_chk #(
  parameter int ACT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_last,
  input logic             out_valid,
  input logic [31:0]      out_sum,
  input logic [ACT_W-1:0] out_act,
  input logic             mul_done,
  input logic [31:0]      acc_q
);
  localparam logic [ACT_W-1:0] HALF = ACT_W'(1 << (ACT_W - 3));
  localparam logic [ACT_W-1:0] ONE  = ACT_W'(1 << (ACT_W - 2));

  // R3: a result appears only 7 edges after a flagged last synapse
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_last, 7));

  // R7: a cycle without a resolved product leaves the accumulator untouched
  p_bubble_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_done |=> $stable(acc_q));

  // R8: non-negative sum gives at least one half
  p_pos_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sum[31]) |-> (out_act >= HALF));

  // R8: negative sum gives at most one half
  p_neg_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sum[31]) |-> (out_act <= HALF));

  // R8: sigmoid never exceeds one
  p_act_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_act <= ONE));
endmodule

bind neuron_mac_sigmoid nsig_core_chk #(.ACT_W(LUT_OUT_FRAC + 2)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_last  (in_last),
  .out_valid(out_valid),
  .out_sum  (out_sum),
  .out_act  (out_act),
  .mul_done (p5_valid),
  .acc_q    (acc_q)
);

// File: tb/neuron_mac_sigmoid_bench.sv
module neuron_mac_sigmoid_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXR = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic [31:0] in_weight = '0;
  logic [31:0] in_act = '0;
  logic        out_valid;
  logic [31:0] out_sum;
  logic [16:0] out_act;

  neuron_mac_sigmoid u_neuron_mac_sigmoid (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_weight(in_weight), .in_act(in_act),
    .out_valid(out_valid), .out_sum(out_sum), .out_act(out_act)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // observed results
  logic [31:0] got_sum [MAXR];
  logic [16:0] got_act [MAXR];
  int          got_cyc [MAXR];
  int          n_got = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid && n_got < MAXR) begin
      got_sum[n_got] = out_sum;
      got_act[n_got] = out_act;
      got_cyc[n_got] = cyc;
      n_got++;
    end
  end

  // expected results
  longint exp_acc = 0;
  bit     exp_fresh = 1'b1;
  logic [31:0] exp_sum [MAXR];
  int          exp_cyc [MAXR];
  int          n_exp = 0;

  function automatic longint clamp32(input longint v);
    if (v > 64'sd2147483647)  return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic int ref_act(input logic [31:0] s);
    longint v;
    int     idx;
    real    x;
    real    sg;
    v = longint'($signed(s));
    if (v > 65535)  v = 65535;
    if (v < -65536) v = -65536;
    idx = int'((v + 65536) / 2048);
    x   = (real'(idx) - 31.5) / 16.0;
    sg  = 1.0 / (1.0 + $exp(-x));
    return $rtoi(sg * 32768.0 + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [31:0] a, input bit last);
    longint p;
    @(negedge clk);
    in_valid  = 1'b1;
    in_last   = last;
    in_weight = w;
    in_act    = a;
    p = (longint'($signed(w)) * longint'($signed(a))) >>> 15;
    p = clamp32(p);
    exp_acc   = clamp32((exp_fresh ? 64'sd0 : exp_acc) + p);
    exp_fresh = last;
    if (last) begin
      exp_sum[n_exp] = exp_acc[31:0];
      exp_cyc[n_exp] = cyc + 7;
      n_exp++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  task automatic begin_case();
    idle(1);
    n_got = 0;
    n_exp = 0;
  endtask

  task automatic judge(input string req);
    idle(12);
    check(n_got == n_exp, req, "result count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      int ea;
      int da;
      ea = ref_act(exp_sum[i]);
      da = int'(got_act[i]) - ea;
      check(got_sum[i] == exp_sum[i], req, $sformatf("sum #%0d", i),
            longint'($signed(got_sum[i])), longint'($signed(exp_sum[i])));
      check(da >= -1 && da <= 1, "R8", $sformatf("%s act #%0d", req, i), got_act[i], ea);
      check(got_cyc[i] == exp_cyc[i], "R3", $sformatf("%s timing #%0d", req, i),
            got_cyc[i], exp_cyc[i]);
    end
  endtask

  // R1: reset state
  task automatic t_reset();
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(out_sum == 32'd0, "R1", "out_sum after reset", out_sum, 0);
    check(out_act == 17'd0, "R1", "out_act after reset", out_act, 0);
  endtask

  // R2: one neuron, mixed signs, one synapse per cycle
  task automatic t_basic();
    begin_case();
    send(32'sd16384,  32'sd32768, 1'b0);
    send(-32'sd8192,  32'sd24576, 1'b0);
    send(32'sd40000, -32'sd12345, 1'b0);
    send(32'sd777,    32'sd99999, 1'b1);
    judge("R2");
  endtask

  // R6: consecutive neurons, including one-synapse ones, no gap
  task automatic t_back_to_back();
    begin_case();
    send(32'sd65536,  32'sd32768, 1'b0);
    send(32'sd1000,   32'sd2000,  1'b1);
    send(-32'sd5000,  32'sd32768, 1'b1);
    send(32'sd123456, 32'sd4096,  1'b1);
    send(32'sd3,      -32'sd7,    1'b0);
    send(-32'sd30000, 32'sd30000, 1'b1);
    judge("R6");
  endtask

  // R7: bubbles inside a neuron and between neurons
  task automatic t_bubbles();
    begin_case();
    send(32'sd16384, 32'sd32768, 1'b0);
    idle(3);
    send(-32'sd8192, 32'sd24576, 1'b0);
    idle(1);
    send(32'sd40000, -32'sd12345, 1'b1);
    idle(9);
    send(32'sd20000, 32'sd16384, 1'b1);
    judge("R7");
  endtask

  // R4: product saturation, including the Booth extreme pair
  task automatic t_prod_sat();
    begin_case();
    send(32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1);
    send(32'h80000000, 32'h80000000, 1'b1);
    send(32'h80000000, 32'h7FFFFFFF, 1'b1);
    send(32'h00010000, 32'h80000000, 1'b1);
    judge("R4");
  endtask

  // R5: accumulator saturation in both directions
  task automatic t_acc_sat();
    begin_case();
    send(32'h7FFFFFFF, 32'h00010000, 1'b0);
    send(32'h7FFFFFFF, 32'h00010000, 1'b0);
    send(-32'sd32768,  32'sd32768,   1'b1);
    send(32'h80000000, 32'h00008000, 1'b0);
    send(32'h80000000, 32'h00008000, 1'b1);
    judge("R5");
  endtask

  // R9: sums beyond the table range select the end entries
  task automatic t_clamp();
    begin_case();
    send(32'sd163840,  32'sd32768, 1'b1);
    send(-32'sd163840, 32'sd32768, 1'b1);
    send(32'sd65535,   32'sd32768, 1'b1);
    send(-32'sd65536,  32'sd32768, 1'b1);
    judge("R9");
  endtask

  // R8: sweep the sum across the table
  task automatic t_sweep();
    begin_case();
    for (int k = -36; k <= 36; k++) send(32'(k * 2048 + 517), 32'sd32768, 1'b1);
    judge("R8");
  endtask

  // R2: pseudo-random neurons of varying length
  task automatic t_mixed();
    int unsigned seed;
    seed = 32'h1234_5678;
    begin_case();
    for (int n = 0; n < 20; n++) begin
      for (int s = 0; s <= n % 5; s++) begin
        logic [31:0] w;
        logic [31:0] a;
        seed = seed * 1664525 + 1013904223;
        w = 32'($signed(seed) >>> 12);
        seed = seed * 1664525 + 1013904223;
        a = 32'($signed(seed) >>> 13);
        send(w, a, s == n % 5);
      end
    end
    judge("R2");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_basic();
    t_back_to_back();
    t_bubbles();
    t_prod_sat();
    t_acc_sat();
    t_clamp();
    t_sweep();
    t_mixed();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule